// File: doc/BRIEF.md
# Debug Breakpoint and Watchpoint Matcher

This block sits beside a processor core's fetch and load/store paths and compares every presented instruction fetch address and data access address against a set of programmable comparators. Six instruction breakpoints and four data watchpoints are provided. The two highest breakpoints can be switched into context mode, where they compare the current process context identifier instead of an address. In that mode they serve only as qualifiers for watchpoints that link to them.

A debugger or software programs the comparator values and controls through a 32-bit APB slave port. The port inserts no wait states and reports an error on unmapped offsets. Hits come out one clock after the qualifying access, with one bit per comparator plus a summary bit for each family.

Register offsets (byte addresses, word aligned): breakpoint value `i` at 0x00+4i, breakpoint control `i` at 0x20+4i, watchpoint value `j` at 0x40+4j, watchpoint control `j` at 0x60+4j.

Top module: `dbg_match_unit`

## Requirements
- R1: Six breakpoints and four watchpoints each drive their own bit of `bp_hit`/`wp_hit`; a hit appears on the first rising edge after the access is presented, and all hits and registers are 0 after reset.
- R2: A breakpoint in address mode hits when `if_valid` is 1 and `if_addr[31:2]` equals its value bits [31:2]; fetch address bits [1:0] are ignored.
- R3: Breakpoint control bit 1 selects context mode only on breakpoints 4 and 5; on breakpoints 0 to 3 a written 1 in bit 1 is dropped, reads back 0 and leaves the breakpoint in address mode.
- R4: A breakpoint in context mode never raises its own hit bit, even if the fetch address equals its value.
- R5: A watchpoint matches any data address with `da_addr[31:3]` equal to its value bits [31:3] (one aligned 8-byte window) while `da_valid` is 1.
- R6: Watchpoint control bit 1 enables load matches (`da_write`=0) and bit 2 enables store matches (`da_write`=1); an access of a disabled direction never hits.
- R7: With watchpoint control bit 3 set, a hit also requires the breakpoint chosen by control bit 4 (0 = breakpoint 4, 1 = breakpoint 5) to be enabled, in context mode, and have a value equal to `ctx_id`.
- R8: Control bit 0 is the enable of every comparator; a cleared enable never produces a hit.
- R9: `bp_any` is the OR of `bp_hit` and `wp_any` the OR of `wp_hit`, in the same cycle.
- R10: All value and control registers are read and written through APB at the offsets listed above; value registers hold 32 bits, breakpoint control reads {ctx,en} in bits [1:0], watchpoint control reads {sel,link,store,load,en} in bits [4:0].
- R11: `pready` is always 1; `pslverr` is 1 in the access phase of any unmapped or misaligned offset, and a write there changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | 8 | APB byte offset |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, tied high |
| pslverr | output | 1 | APB error for unmapped offsets |
| if_valid | input | 1 | Instruction fetch present |
| if_addr | input | 32 | Instruction fetch virtual address |
| ctx_id | input | 32 | Current process context identifier |
| da_valid | input | 1 | Data access present |
| da_write | input | 1 | Data access is a store |
| da_addr | input | 32 | Data access virtual address |
| bp_hit | output | 6 | Per-breakpoint hit |
| wp_hit | output | 4 | Per-watchpoint hit |
| bp_any | output | 1 | Any breakpoint hit |
| wp_any | output | 1 | Any watchpoint hit |

## Verification
Hits are due exactly one rising edge after a fetch or data access is driven, so the bench drives on a falling edge, confirms the hit bits are still 0 shortly after, and samples them on the next falling edge, when the registered result is stable. APB read data and the error flag are combinational in the access phase and are sampled 1 ns after `penable` rises. Register writes take effect on the edge that closes that access phase, so a follow-up read or access sees the new setting.

// File: rtl/dbg_match_pkg.sv
package dbg_match_pkg;
    localparam int DW       = 32;
    localparam int AW       = DW;
    localparam int NUM_BP   = 6;
    localparam int NUM_WP   = 4;
    localparam int NUM_CTX  = 2;
    localparam int CTX_BASE = NUM_BP - NUM_CTX;
    localparam int LSW      = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1;
    localparam int BIB      = $clog2(NUM_BP);
    localparam int WIB      = $clog2(NUM_WP);

    // register groups selected by paddr[7:5]
    typedef enum logic [2:0] {
        GRP_BP_VAL  = 3'd0,
        GRP_BP_CTRL = 3'd1,
        GRP_WP_VAL  = 3'd2,
        GRP_WP_CTRL = 3'd3
    } reg_grp_e;

    typedef struct packed {
        logic ctx;
        logic en;
    } bp_cfg_t;

    typedef struct packed {
        logic [LSW-1:0] sel;
        logic           link;
        logic           st;
        logic           ld;
        logic           en;
    } wp_cfg_t;

    function automatic logic same_window(input logic [AW-1:0] a,
                                         input logic [AW-1:0] b,
                                         input int unsigned   lsb);
        logic [AW-1:0] mask;
        mask = ~((AW'(1) << lsb) - AW'(1));
        return (a & mask) == (b & mask);
    endfunction
endpackage

// File: rtl/dbg_match_regs.sv
module dbg_match_regs
    import dbg_match_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       psel,
    input  logic                       penable,
    input  logic                       pwrite,
    input  logic [7:0]                 paddr,
    input  logic [DW-1:0]              pwdata,
    output logic [DW-1:0]              prdata,
    output logic                       pslverr,
    output bp_cfg_t [NUM_BP-1:0]       bp_cfg,
    output logic [NUM_BP-1:0][AW-1:0]  bp_val,
    output wp_cfg_t [NUM_WP-1:0]       wp_cfg,
    output logic [NUM_WP-1:0][AW-1:0]  wp_val
);
    logic [2:0] grp;
    logic [2:0] idx;
    logic       mapped;
    logic       acc;
    logic       wr;

    assign grp = paddr[7:5];
    assign idx = paddr[4:2];
    assign acc = psel && penable;
    assign wr  = acc && pwrite && mapped;

    always_comb begin
        mapped = 1'b0;
        if (paddr[1:0] == 2'b00) begin
            case (grp)
                GRP_BP_VAL, GRP_BP_CTRL: mapped = int'(idx) < NUM_BP;
                GRP_WP_VAL, GRP_WP_CTRL: mapped = int'(idx) < NUM_WP;
                default:                 mapped = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bp_cfg <= '0;
            bp_val <= '0;
            wp_cfg <= '0;
            wp_val <= '0;
        end else if (wr) begin
            for (int i = 0; i < NUM_BP; i++) begin
                if (int'(idx) == i) begin
                    if (grp == GRP_BP_VAL) bp_val[i] <= pwdata;
                    if (grp == GRP_BP_CTRL) begin
                        bp_cfg[i].en  <= pwdata[0];
                        bp_cfg[i].ctx <= (i >= CTX_BASE) && pwdata[1];
                    end
                end
            end
            for (int j = 0; j < NUM_WP; j++) begin
                if (int'(idx) == j) begin
                    if (grp == GRP_WP_VAL) wp_val[j] <= pwdata;
                    if (grp == GRP_WP_CTRL) begin
                        wp_cfg[j].en   <= pwdata[0];
                        wp_cfg[j].ld   <= pwdata[1];
                        wp_cfg[j].st   <= pwdata[2];
                        wp_cfg[j].link <= pwdata[3];
                        wp_cfg[j].sel  <= pwdata[4 +: LSW];
                    end
                end
            end
        end
    end

    always_comb begin
        prdata = '0;
        if (acc && mapped) begin
            case (grp)
                GRP_BP_VAL:  prdata = bp_val[idx[BIB-1:0]];
                GRP_BP_CTRL: prdata = DW'(bp_cfg[idx[BIB-1:0]]);
                GRP_WP_VAL:  prdata = wp_val[idx[WIB-1:0]];
                GRP_WP_CTRL: prdata = DW'(wp_cfg[idx[WIB-1:0]]);
                default:     prdata = '0;
            endcase
        end
    end

    assign pslverr = acc && !mapped;

    // R11: an erroring write leaves every register untouched
    assert_bad_write_no_effect_R11: assert property (@(posedge clk) disable iff (rst)
        (psel && penable && pwrite && pslverr) |=>
            ($stable(bp_val) && $stable(bp_cfg) && $stable(wp_val) && $stable(wp_cfg)));
endmodule

// File: rtl/dbg_bp_cmp.sv
module dbg_bp_cmp
    import dbg_match_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  bp_cfg_t       cfg,
    input  logic [AW-1:0] val,
    input  logic          if_valid,
    input  logic [AW-1:0] if_addr,
    output logic          hit
);
    logic hit_d;

    assign hit_d = cfg.en && !cfg.ctx && if_valid && same_window(if_addr, val, 2);

    always_ff @(posedge clk) begin
        if (rst) hit <= 1'b0;
        else     hit <= hit_d;
    end

    // R4: context mode breakpoints stay silent
    assert_ctx_mode_silent_R4: assert property (@(posedge clk) disable iff (rst)
        cfg.ctx |=> !hit);
    // R8: disabled breakpoint stays silent
    assert_bp_disabled_silent_R8: assert property (@(posedge clk) disable iff (rst)
        !cfg.en |=> !hit);
endmodule

// File: rtl/dbg_wp_cmp.sv
module dbg_wp_cmp
    import dbg_match_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  wp_cfg_t            cfg,
    input  logic [AW-1:0]      val,
    input  logic               da_valid,
    input  logic               da_write,
    input  logic [AW-1:0]      da_addr,
    input  logic [NUM_CTX-1:0] ctx_ok,
    output logic               hit
);
    logic dir_ok;
    logic link_ok;
    logic hit_d;

    assign dir_ok  = da_write ? cfg.st : cfg.ld;
    assign link_ok = !cfg.link || ctx_ok[cfg.sel];
    assign hit_d   = cfg.en && da_valid && dir_ok && link_ok
                     && same_window(da_addr, val, 3);

    always_ff @(posedge clk) begin
        if (rst) hit <= 1'b0;
        else     hit <= hit_d;
    end

    // R5: no access, no hit
    assert_wp_idle_silent_R5: assert property (@(posedge clk) disable iff (rst)
        !da_valid |=> !hit);
    // R7: a linked watchpoint needs its context breakpoint to agree
    assert_link_gate_R7: assert property (@(posedge clk) disable iff (rst)
        (cfg.link && !ctx_ok[cfg.sel]) |=> !hit);
    // R6: wrong direction never hits
    assert_dir_gate_R6: assert property (@(posedge clk) disable iff (rst)
        (da_valid && da_write && !cfg.st) |=> !hit);
endmodule

// File: rtl/dbg_match_unit.sv
module dbg_match_unit
    import dbg_match_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [7:0]        paddr,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata,
    output logic              pready,
    output logic              pslverr,
    input  logic              if_valid,
    input  logic [31:0]       if_addr,
    input  logic [31:0]       ctx_id,
    input  logic              da_valid,
    input  logic              da_write,
    input  logic [31:0]       da_addr,
    output logic [NUM_BP-1:0] bp_hit,
    output logic [NUM_WP-1:0] wp_hit,
    output logic              bp_any,
    output logic              wp_any
);
    bp_cfg_t [NUM_BP-1:0]      bp_cfg;
    logic [NUM_BP-1:0][AW-1:0] bp_val;
    wp_cfg_t [NUM_WP-1:0]      wp_cfg;
    logic [NUM_WP-1:0][AW-1:0] wp_val;
    logic [NUM_CTX-1:0]        ctx_ok;

    dbg_match_regs u_regs (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pslverr(pslverr),
        .bp_cfg(bp_cfg), .bp_val(bp_val), .wp_cfg(wp_cfg), .wp_val(wp_val)
    );

    assign pready = 1'b1;

    for (genvar k = 0; k < NUM_CTX; k++) begin : g_ctx
        assign ctx_ok[k] = bp_cfg[CTX_BASE+k].en && bp_cfg[CTX_BASE+k].ctx
                           && (bp_val[CTX_BASE+k] == ctx_id);
    end

    for (genvar i = 0; i < NUM_BP; i++) begin : g_bp
        dbg_bp_cmp u_bp (
            .clk(clk), .rst(rst), .cfg(bp_cfg[i]), .val(bp_val[i]),
            .if_valid(if_valid), .if_addr(if_addr), .hit(bp_hit[i])
        );
    end

    for (genvar j = 0; j < NUM_WP; j++) begin : g_wp
        dbg_wp_cmp u_wp (
            .clk(clk), .rst(rst), .cfg(wp_cfg[j]), .val(wp_val[j]),
            .da_valid(da_valid), .da_write(da_write), .da_addr(da_addr),
            .ctx_ok(ctx_ok), .hit(wp_hit[j])
        );
    end

    assign bp_any = |bp_hit;
    assign wp_any = |wp_hit;

    // R2: no fetch presented, no breakpoint hit next cycle
    assert_fetch_idle_silent_R2: assert property (@(posedge clk) disable iff (rst)
        !if_valid |=> (bp_hit == '0));
    // R11: the port never stalls
    assert_no_wait_R11: assert property (@(posedge clk) disable iff (rst)
        (psel && penable) |-> pready);
endmodule

// File: tb/dbg_match_unit_tb.sv
module dbg_match_unit_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        psel = 0, penable = 0, pwrite = 0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready, pslverr;
    logic        if_valid = 0;
    logic [31:0] if_addr = '0, ctx_id = '0, da_addr = '0;
    logic        da_valid = 0, da_write = 0;
    logic [5:0]  bp_hit;
    logic [3:0]  wp_hit;
    logic        bp_any, wp_any;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 0;

    dbg_match_unit u_dut (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
        .pslverr(pslverr), .if_valid(if_valid), .if_addr(if_addr), .ctx_id(ctx_id),
        .da_valid(da_valid), .da_write(da_write), .da_addr(da_addr),
        .bp_hit(bp_hit), .wp_hit(wp_hit), .bp_any(bp_any), .wp_any(wp_any)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    task automatic apb(input logic wr, input logic [7:0] a, input logic [31:0] d,
                       output logic [31:0] rd, output logic err, output logic rdy);
        @(negedge clk);
        psel = 1; penable = 0; pwrite = wr; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1;
        #1;
        rd = prdata; err = pslverr; rdy = pready;
        @(negedge clk);
        psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
        logic [31:0] rd; logic err, rdy;
        apb(1'b1, a, d, rd, err, rdy);
        chk("R11 write pslverr", {31'b0, err}, 32'd0);
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] rd; logic err, rdy;
        apb(1'b0, a, 32'd0, rd, err, rdy);
        chk(tag, rd, exp);
    endtask

    task automatic fetch(input string tag, input logic v, input logic [31:0] a,
                         input logic [5:0] exp);
        @(negedge clk);
        if_valid = v; if_addr = a;
        #1 chk({tag, " (R1 not yet)"}, {26'b0, bp_hit}, 32'd0);
        @(negedge clk);
        if_valid = 0;
        chk(tag, {26'b0, bp_hit}, {26'b0, exp});
        chk({tag, " R9 bp_any"}, {31'b0, bp_any}, {31'b0, |exp});
        @(negedge clk);
    endtask

    task automatic access(input string tag, input logic [31:0] a, input logic w,
                          input logic [31:0] ctx, input logic [3:0] exp);
        @(negedge clk);
        da_valid = 1; da_write = w; da_addr = a; ctx_id = ctx;
        #1 chk({tag, " (R1 not yet)"}, {28'b0, wp_hit}, 32'd0);
        @(negedge clk);
        da_valid = 0;
        chk(tag, {28'b0, wp_hit}, {28'b0, exp});
        chk({tag, " R9 wp_any"}, {31'b0, wp_any}, {31'b0, |exp});
        @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R1 reset bp_hit", {26'b0, bp_hit}, 32'd0);
        chk("R1 reset wp_hit", {28'b0, wp_hit}, 32'd0);
        rd_chk("R10 reset bp3 value", 8'h0C, 32'd0);
        rd_chk("R10 reset wp2 ctrl", 8'h68, 32'd0);
    endtask

    task automatic t_regs;
        wr_reg(8'h14, 32'h1234_5677);
        rd_chk("R10 bp5 value", 8'h14, 32'h1234_5677);
        wr_reg(8'h4C, 32'hCAFE_F00D);
        rd_chk("R10 wp3 value", 8'h4C, 32'hCAFE_F00D);
        wr_reg(8'h64, 32'hFFFF_FFFF);
        rd_chk("R10 wp1 ctrl", 8'h64, 32'h0000_001F);
        wr_reg(8'h20, 32'h3);
        rd_chk("R3 bp0 ctx bit dropped", 8'h20, 32'h1);
        wr_reg(8'h30, 32'h3);
        rd_chk("R3 bp4 ctx bit kept", 8'h30, 32'h3);
        wr_reg(8'h64, 32'h0);
        wr_reg(8'h20, 32'h0);
        wr_reg(8'h30, 32'h0);
    endtask

    task automatic t_errors;
        logic [31:0] rd; logic err, rdy;
        apb(1'b1, 8'h18, 32'hDEAD_BEEF, rd, err, rdy);
        chk("R11 bp6 slot pslverr", {31'b0, err}, 32'd1);
        chk("R11 pready", {31'b0, rdy}, 32'd1);
        apb(1'b1, 8'h50, 32'hDEAD_BEEF, rd, err, rdy);
        chk("R11 wp4 slot pslverr", {31'b0, err}, 32'd1);
        apb(1'b1, 8'h82, 32'hDEAD_BEEF, rd, err, rdy);
        chk("R11 high offset pslverr", {31'b0, err}, 32'd1);
        apb(1'b1, 8'h15, 32'hDEAD_BEEF, rd, err, rdy);
        chk("R11 misaligned pslverr", {31'b0, err}, 32'd1);
        rd_chk("R11 bp5 value untouched", 8'h14, 32'h1234_5677);
        rd_chk("R11 wp0 value untouched", 8'h40, 32'd0);
    endtask

    task automatic t_bp_addr;
        wr_reg(8'h08, 32'h0000_1000);
        wr_reg(8'h28, 32'h1);
        fetch("R2 bp2 low bits ignored", 1'b1, 32'h0000_1003, 6'b000100);
        fetch("R2 bp2 next word miss", 1'b1, 32'h0000_1004, 6'b000000);
        fetch("R2 bp2 no valid", 1'b0, 32'h0000_1000, 6'b000000);
        wr_reg(8'h28, 32'h0);
        fetch("R8 bp2 disabled", 1'b1, 32'h0000_1000, 6'b000000);
        wr_reg(8'h00, 32'h0000_1000);
        wr_reg(8'h20, 32'h3);
        fetch("R3 bp0 stays address mode", 1'b1, 32'h0000_1001, 6'b000001);
        wr_reg(8'h20, 32'h0);
    endtask

    task automatic t_bp_ctx;
        wr_reg(8'h10, 32'h0000_2000);
        wr_reg(8'h30, 32'h1);
        fetch("R3 bp4 address mode hit", 1'b1, 32'h0000_2002, 6'b010000);
        wr_reg(8'h10, 32'h0000_0055);
        wr_reg(8'h30, 32'h3);
        ctx_id = 32'h55;
        fetch("R4 bp4 context mode silent", 1'b1, 32'h0000_0055, 6'b000000);
        wr_reg(8'h30, 32'h0);
    endtask

    task automatic t_wp_window;
        wr_reg(8'h44, 32'h0000_3008);
        wr_reg(8'h64, 32'h3);
        access("R5 wp1 window top", 32'h0000_300F, 1'b0, 32'd0, 4'b0010);
        access("R5 wp1 window base", 32'h0000_3008, 1'b0, 32'd0, 4'b0010);
        access("R5 wp1 above window", 32'h0000_3010, 1'b0, 32'd0, 4'b0000);
        access("R5 wp1 below window", 32'h0000_3007, 1'b0, 32'd0, 4'b0000);
        access("R6 wp1 store blocked", 32'h0000_3008, 1'b1, 32'd0, 4'b0000);
        wr_reg(8'h64, 32'h5);
        access("R6 wp1 store hit", 32'h0000_300C, 1'b1, 32'd0, 4'b0010);
        access("R6 wp1 load blocked", 32'h0000_300C, 1'b0, 32'd0, 4'b0000);
        wr_reg(8'h64, 32'h6);
        access("R8 wp1 disabled", 32'h0000_300C, 1'b1, 32'd0, 4'b0000);
        wr_reg(8'h64, 32'h0);
    endtask

    task automatic t_link;
        wr_reg(8'h40, 32'h0000_4000);
        wr_reg(8'h14, 32'h0000_00AB);
        wr_reg(8'h34, 32'h3);
        wr_reg(8'h60, 32'h1B);
        access("R7 wp0 linked bp5 ctx match", 32'h0000_4004, 1'b0, 32'hAB, 4'b0001);
        access("R7 wp0 linked bp5 ctx mismatch", 32'h0000_4004, 1'b0, 32'hAC, 4'b0000);
        wr_reg(8'h60, 32'h0B);
        access("R7 wp0 linked bp4 not ctx", 32'h0000_4004, 1'b0, 32'hAB, 4'b0000);
        wr_reg(8'h60, 32'h1B);
        wr_reg(8'h34, 32'h1);
        access("R7 wp0 bp5 address mode", 32'h0000_4004, 1'b0, 32'hAB, 4'b0000);
        wr_reg(8'h60, 32'h03);
        access("R7 wp0 unlinked ignores ctx", 32'h0000_4004, 1'b0, 32'hAC, 4'b0001);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_regs();
        t_errors();
        t_bp_addr();
        t_bp_ctx();
        t_wp_window();
        t_link();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule